// File: doc/BRIEF.md
# Byte-Wide SRAM Self-Test Engine

This block drives a synchronous single-port byte-wide static RAM through an autonomous self-test and reports the first failing location. A pulse on `start` samples the size selection and launches the test. The test has two phases. The address phase first fills the selected region with background byte A and verifies each write. It then exercises every address line on its own: byte B goes to the location whose address has only that line high, every other location is read back and must still hold A, and A is written back before the next line. Address zero, with no line set, is taken first as a reference location. The data phase walks six patterns in a fixed order. For each pattern and each byte it writes the pattern, reads it back, writes the bitwise complement and reads that back.

The engine is a single state machine. `IDLE` and `DONE` leave on `start` into `FILL_WR`. `FILL_WR` goes to `FILL_RD`, then to `WAIT`. After the last fill compare, `WAIT` goes to `LINE_WR`, which leads to `LINE_RD`. `LINE_RD` skips the test address, issues the other reads and goes to `WAIT`, which returns to `LINE_RD`. After the last scanned location the machine enters `LINE_RESTORE`. `LINE_RESTORE` goes to `LINE_WR` for the next line, or to `DATA_WR` after the last line. `DATA_WR` goes to `DATA_RD`, then to `WAIT`, which loops back to `DATA_WR`. After the last compare of the last pattern, `WAIT` moves to `DONE`. Any miscompare in `WAIT` also moves to `DONE`.

A smaller size setting confines every access to the lower part of the array. Contents are not preserved.

Top module: `sram_bist_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `fail` are low, `err_code` is 0 and `mem_we` is low. `mem_we` is never high while `busy` is low.
- R2: `start` samples `size_sel`, mapping 0 to 2^LOG_SMALL bytes, 1 to 2^LOG_MID bytes, and 2 or 3 to 2^LOG_LARGE bytes. Every address driven during the run lies below the selected size, the highest one is reached, and bytes above the region are left untouched.
- R3: The fill writes A (default 0x00) to every location in ascending order and reads each one back. A miscompare there gives `err_code` 1 (initialization).
- R4: For the reference address 0 and then for each address with a single line set, from line 0 upward, the engine writes B (default 0xFF) there and checks that every other location reads A. A miscompare gives `err_code` 2 (addressing).
- R5: After each line check, A is written back to the test address. With no fault, the write sequence seen at location 0 is 00, FF, 00 before the data phase starts.
- R6: The data phase uses the pattern order 0x55, 0xAA, 0x33, 0xCC, 0x00, 0xFF. Each byte gets the pattern and then its complement. Location 0 therefore receives 55, AA, AA, 55, 33, CC, CC, 33, 00, FF, FF, 00, and a clean run leaves 0x00 in every tested byte.
- R7: A miscompare in the data phase gives `err_code` 3 (data).
- R8: The first miscompare ends the run. `fail_addr`, `fail_exp` and `fail_act` latch the location, the expected byte and the byte read. `done` and `fail` rise together with `busy` falling, and all of these hold until the next start.
- R9: A run without a miscompare ends with `done` and `pass` high, `fail` low and `err_code` 0.
- R10: Read data is taken exactly RD_LAT cycles after a read address is presented with `mem_we` low, and at most one read is in flight.
- R11: A `start` pulse while `busy` is high is ignored, and the running test finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| size_sel | input | 2 | Size selection sampled at start |
| mem_addr | output | LOG_LARGE | RAM address |
| mem_wdata | output | 8 | RAM write byte |
| mem_we | output | 1 | RAM write enable; low means read |
| mem_rdata | input | 8 | RAM read byte, RD_LAT cycles after address |
| busy | output | 1 | Test running |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no miscompare |
| fail | output | 1 | Finished on a miscompare |
| err_code | output | 2 | 0 none, 1 initialization, 2 addressing, 3 data |
| fail_addr | output | LOG_LARGE | First failing address |
| fail_exp | output | 8 | Expected byte at the failure |
| fail_act | output | 8 | Byte actually read at the failure |

## Verification
The assertions assume that the RAM returns the byte for a read address exactly RD_LAT cycles later, that it returns it whatever else happens on the bus, and that `size_sel` matters only in the start cycle. The bench memory model has a latency pipeline of the same depth as the parameter. Stuck bits and aliased address lines are injected into the model only while the engine is idle, so a fault never changes in the middle of a run. Start pulses arrive at random points, including one during a run, and the stimulus never depends on internal state.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL_WR,
        S_FILL_RD,
        S_LINE_WR,
        S_LINE_RD,
        S_LINE_RESTORE,
        S_DATA_WR,
        S_DATA_RD,
        S_WAIT,
        S_DONE
    } bist_state_e;

    // Doubles as the phase tag of the read in flight.
    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_INIT = 2'd1,
        ERR_ADDR = 2'd2,
        ERR_DATA = 2'd3
    } bist_err_e;

    localparam int NUM_PAT = 6;

    function automatic logic [7:0] pat_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h55;
            3'd1:    b = 8'hAA;
            3'd2:    b = 8'h33;
            3'd3:    b = 8'hCC;
            3'd4:    b = 8'h00;
            default: b = 8'hFF;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bist_rd_tracker.sv
module bist_rd_tracker #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic valid
);
    logic [RD_LAT-1:0] sr_q;

    generate
        if (RD_LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= issue;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[RD_LAT-2:0], issue};
            end
        end
    endgenerate

    assign valid = sr_q[RD_LAT-1];

    // R10: at most one read travels through the latency pipe
    p_one_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sr_q));

    // R10: a new read is issued only once the pipe has drained
    p_issue_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (sr_q == '0));

endmodule

// File: rtl/bist_fail_latch.sv
module bist_fail_latch #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          chk,
    input  logic [7:0]    exp_byte,
    input  logic [7:0]    act_byte,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    code,
    output logic          miss,
    output logic          fail,
    output logic [1:0]    err_code,
    output logic [AW-1:0] fail_addr,
    output logic [7:0]    fail_exp,
    output logic [7:0]    fail_act
);
    assign miss = chk && (exp_byte != act_byte);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail      <= 1'b0;
            err_code  <= 2'd0;
            fail_addr <= '0;
            fail_exp  <= 8'h00;
            fail_act  <= 8'h00;
        end else if (miss && !fail) begin
            fail      <= 1'b1;
            err_code  <= code;
            fail_addr <= addr;
            fail_exp  <= exp_byte;
            fail_act  <= act_byte;
        end
    end

    // R8: the captured failure record holds until the next start
    p_record_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_act)
                            && $stable(fail_exp) && $stable(err_code)));

    // R8: a failure always carries a nonzero error code
    p_code_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (err_code != 2'd0));

endmodule

// File: rtl/sram_bist_engine.sv
module sram_bist_engine
    import sram_bist_pkg::*;
#(
    parameter int         LOG_SMALL = 15,
    parameter int         LOG_MID   = 17,
    parameter int         LOG_LARGE = 19,
    parameter int         RD_LAT    = 1,
    parameter logic [7:0] PAT_A     = 8'h00,
    parameter logic [7:0] PAT_B     = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           size_sel,
    output logic [LOG_LARGE-1:0] mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 mem_we,
    input  logic [7:0]           mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 pass,
    output logic                 fail,
    output logic [1:0]           err_code,
    output logic [LOG_LARGE-1:0] fail_addr,
    output logic [7:0]           fail_exp,
    output logic [7:0]           fail_act
);
    localparam int AW = LOG_LARGE;
    localparam int LW = $clog2(AW + 1);

    bist_state_e   state_q, state_d;
    bist_err_e     ret_q, ret_d;
    logic [AW-1:0] scan_q, scan_d;
    logic [LW-1:0] line_q, line_d;
    logic [LW-1:0] size_q, size_d;
    logic [2:0]    pat_q, pat_d;
    logic          cpl_q, cpl_d;

    logic [LW-1:0] sel_log;
    logic [AW:0]   span;
    logic [AW-1:0] last_addr, tst_addr;
    logic          at_last;
    logic [7:0]    data_byte, exp_byte;
    logic          rd_issue, rd_valid, chk, miss, start_ok;

    always_comb begin
        unique case (size_sel)
            2'd0:    sel_log = LW'(LOG_SMALL);
            2'd1:    sel_log = LW'(LOG_MID);
            default: sel_log = LW'(LOG_LARGE);
        endcase
    end

    assign span      = (AW+1)'(1) << size_q;
    assign last_addr = AW'(span - (AW+1)'(1));
    assign at_last   = (scan_q == last_addr);
    assign tst_addr  = (line_q == '0) ? '0 : (AW'(1) << (line_q - LW'(1)));
    assign data_byte = cpl_q ? ~pat_byte(pat_q) : pat_byte(pat_q);
    assign exp_byte  = (ret_q == ERR_DATA) ? data_byte : PAT_A;
    assign start_ok  = start && !busy;
    assign chk       = (state_q == S_WAIT) && rd_valid;

    // next-state and sequencing registers
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        scan_d  = scan_q;
        line_d  = line_q;
        size_d  = size_q;
        pat_d   = pat_q;
        cpl_d   = cpl_q;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    size_d  = sel_log;
                    scan_d  = '0;
                    line_d  = '0;
                    pat_d   = 3'd0;
                    cpl_d   = 1'b0;
                    ret_d   = ERR_INIT;
                    state_d = S_FILL_WR;
                end
            end
            S_FILL_WR: state_d = S_FILL_RD;
            S_FILL_RD: state_d = S_WAIT;
            S_LINE_WR: state_d = S_LINE_RD;
            S_LINE_RD: begin
                if (scan_q == tst_addr) begin
                    if (at_last) state_d = S_LINE_RESTORE;
                    else         scan_d  = scan_q + AW'(1);
                end else begin
                    state_d = S_WAIT;
                end
            end
            S_LINE_RESTORE: begin
                scan_d = '0;
                if (line_q == size_q) begin
                    line_d  = '0;
                    ret_d   = ERR_DATA;
                    state_d = S_DATA_WR;
                end else begin
                    line_d  = line_q + LW'(1);
                    state_d = S_LINE_WR;
                end
            end
            S_DATA_WR: state_d = S_DATA_RD;
            S_DATA_RD: state_d = S_WAIT;
            S_WAIT: begin
                if (rd_valid) begin
                    if (miss) begin
                        state_d = S_DONE;
                    end else begin
                        unique case (ret_q)
                            ERR_INIT: begin
                                if (at_last) begin
                                    scan_d  = '0;
                                    line_d  = '0;
                                    ret_d   = ERR_ADDR;
                                    state_d = S_LINE_WR;
                                end else begin
                                    scan_d  = scan_q + AW'(1);
                                    state_d = S_FILL_WR;
                                end
                            end
                            ERR_ADDR: begin
                                if (at_last) state_d = S_LINE_RESTORE;
                                else begin
                                    scan_d  = scan_q + AW'(1);
                                    state_d = S_LINE_RD;
                                end
                            end
                            ERR_DATA: begin
                                if (!cpl_q) begin
                                    cpl_d   = 1'b1;
                                    state_d = S_DATA_WR;
                                end else begin
                                    cpl_d = 1'b0;
                                    if (!at_last) begin
                                        scan_d  = scan_q + AW'(1);
                                        state_d = S_DATA_WR;
                                    end else if (pat_q == 3'(NUM_PAT - 1)) begin
                                        state_d = S_DONE;
                                    end else begin
                                        pat_d   = pat_q + 3'd1;
                                        scan_d  = '0;
                                        state_d = S_DATA_WR;
                                    end
                                end
                            end
                            default: state_d = S_DONE;
                        endcase
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= ERR_NONE;
            scan_q  <= '0;
            line_q  <= '0;
            size_q  <= '0;
            pat_q   <= 3'd0;
            cpl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            scan_q  <= scan_d;
            line_q  <= line_d;
            size_q  <= size_d;
            pat_q   <= pat_d;
            cpl_q   <= cpl_d;
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = scan_q;
        mem_wdata = PAT_A;
        rd_issue  = 1'b0;
        unique case (state_q)
            S_FILL_WR:      mem_we = 1'b1;
            S_FILL_RD:      rd_issue = 1'b1;
            S_LINE_WR: begin
                mem_we    = 1'b1;
                mem_addr  = tst_addr;
                mem_wdata = PAT_B;
            end
            S_LINE_RD:      rd_issue = (scan_q != tst_addr);
            S_LINE_RESTORE: begin
                mem_we   = 1'b1;
                mem_addr = tst_addr;
            end
            S_DATA_WR: begin
                mem_we    = 1'b1;
                mem_wdata = data_byte;
            end
            S_DATA_RD:      rd_issue = 1'b1;
            default:        mem_we = 1'b0;
        endcase
        busy = (state_q != S_IDLE) && (state_q != S_DONE);
        done = (state_q == S_DONE);
        pass = done && !fail;
    end

    bist_rd_tracker #(.RD_LAT(RD_LAT)) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (rd_issue),
        .valid (rd_valid)
    );

    bist_fail_latch #(.AW(AW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .chk       (chk),
        .exp_byte  (exp_byte),
        .act_byte  (mem_rdata),
        .addr      (scan_q),
        .code      (ret_q),
        .miss      (miss),
        .fail      (fail),
        .err_code  (err_code),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act)
    );

    // R1: no write strobe outside a run
    p_no_write_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    // R2: accesses stay inside the selected region
    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_addr <= last_addr));

    // R5: restore is followed by the next line or by the data phase
    p_restore_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LINE_RESTORE) |=> (state_q == S_LINE_WR || state_q == S_DATA_WR));

    // R6: a passing true-pattern compare leads to the complement write of the same byte
    p_cpl_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk && !miss && ret_q == ERR_DATA && !cpl_q)
        |=> (state_q == S_DATA_WR && cpl_q && $stable(scan_q)));

    // R8: busy falling means the run has finished
    p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: fail is only shown together with done
    p_fail_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R8: a miscompare stops the run on the next edge
    p_stop_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (done && fail));

endmodule

// File: tb/sram_bist_engine_bench.sv
module sram_bist_engine_bench;
    localparam int LS    = 4;
    localparam int LM    = 5;
    localparam int LL    = 6;
    localparam int LAT   = 2;
    localparam int DEPTH = 1 << LL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    size_sel = 2'd0;
    logic [LL-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;
    logic          busy, done, pass, fail;
    logic [1:0]    err_code;
    logic [LL-1:0] fail_addr;
    logic [7:0]    fail_exp, fail_act;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #4 clk = ~clk;

    sram_bist_engine #(
        .LOG_SMALL(LS), .LOG_MID(LM), .LOG_LARGE(LL), .RD_LAT(LAT)
    ) u_sram_bist_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .err_code(err_code), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_act(fail_act)
    );

    // memory model with fault injection
    logic [7:0] mem [DEPTH];
    int         alias_bit = -1;
    int         stk_addr  = -1;
    logic [7:0] stk_or    = 8'h00;
    logic [7:0] stk_and   = 8'hFF;
    logic [7:0] q1, q2;
    logic [7:0] wlog [16];
    int         nlog = 0;
    int         maxa = 0;

    function automatic int eff(input int a);
        if (alias_bit >= 0) return a & ~(1 << alias_bit);
        return a;
    endfunction

    function automatic logic [7:0] rd_model(input int a);
        int e;
        logic [7:0] d;
        e = eff(a);
        d = mem[e];
        if (e == stk_addr) d = (d & stk_and) | stk_or;
        return d;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) mem[eff(int'(mem_addr))] <= mem_wdata;
        q1 <= rd_model(int'(mem_addr));
        q2 <= q1;
        if (mem_we && mem_addr == '0 && nlog < 16) begin
            wlog[nlog] <= mem_wdata;
            nlog <= nlog + 1;
        end
        if (busy && int'(mem_addr) > maxa) maxa <= int'(mem_addr);
    end
    assign mem_rdata = q2;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int size_of(input logic [1:0] sel);
        if (sel == 2'd0) return 1 << LS;
        if (sel == 2'd1) return 1 << LM;
        return 1 << LL;
    endfunction

    function automatic int log_of(input logic [1:0] sel);
        if (sel == 2'd0) return LS;
        if (sel == 2'd1) return LM;
        return LL;
    endfunction

    // first failing read for a stuck-at-0 bit: 0x55 if the bit is set there, else its complement
    function automatic logic [7:0] s0_exp(input int b);
        return ((8'h55 >> b) & 8'h01) != 8'h00 ? 8'h55 : 8'hAA;
    endfunction

    task automatic clear_faults();
        alias_bit = -1;
        stk_addr  = -1;
        stk_or    = 8'h00;
        stk_and   = 8'hFF;
    endtask

    task automatic preload();
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hA5;
    endtask

    // returns 1 when the run finished in time
    task automatic run(input logic [1:0] sel, input bit poke, output bit ok);
        int n;
        @(negedge clk);
        maxa = 0;
        nlog = 0;
        size_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        size_sel = 2'd0;
        n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
            if (poke && n == 40) start = 1'b1;
            if (poke && n == 41) start = 1'b0;
        end
        ok = done;
        check(done, "R8 run finished", int'(done), 1);
    endtask

    task automatic expect_fail(input string req, input logic [1:0] code,
                               input int addr, input logic [7:0] e, input logic [7:0] a);
        check(fail && done && !busy && !pass, {req, " fail+done"}, int'(fail), 1);
        check(err_code == code, {req, " code"}, int'(err_code), int'(code));
        check(int'(fail_addr) == addr, {req, " R8 addr"}, int'(fail_addr), addr);
        check(fail_exp == e, {req, " R8 expected"}, int'(fail_exp), int'(e));
        check(fail_act == a, {req, " R8 actual"}, int'(fail_act), int'(a));
    endtask

    task automatic expect_clean(input logic [1:0] sel, input string req);
        int bad;
        int sz;
        sz = size_of(sel);
        check(pass && !fail && err_code == 2'd0, {req, " R9 pass"}, int'(err_code), 0);
        check(maxa == sz - 1, {req, " R2 top address"}, maxa, sz - 1);
        bad = 0;
        for (int i = 0; i < sz; i++) if (mem[i] != 8'h00) bad++;
        check(bad == 0, {req, " R6 final 0x00"}, bad, 0);
        if (sz < DEPTH)
            check(mem[sz] == 8'hA5, {req, " R2 above region"}, int'(mem[sz]), 8'hA5);
    endtask

    logic [7:0] exp_seq [15] = '{8'h00, 8'hFF, 8'h00,
                                 8'h55, 8'hAA, 8'hAA, 8'h55, 8'h33, 8'hCC,
                                 8'hCC, 8'h33, 8'h00, 8'hFF, 8'hFF, 8'h00};

    initial begin
        bit ok;
        int bad;
        void'($urandom(32'd4242));
        clear_faults();
        preload();
        repeat (5) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fail && !pass && err_code == 2'd0 && !mem_we,
              "R1 reset outputs", int'({busy, done, fail, pass}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_we, "R1 idle after reset", int'(busy), 0);

        // clean runs for every size code, R2 size map
        for (int s = 0; s < 4; s++) begin
            preload();
            run(2'(s), 1'b0, ok);
            if (ok) expect_clean(2'(s), "clean");
            if (s == 2) begin
                bad = 0;
                for (int i = 0; i < 15; i++) if (wlog[i] != exp_seq[i]) bad++;
                check(nlog == 15, "R6 write count at 0", nlog, 15);
                check(bad == 0, "R4 R5 R6 write order at 0", bad, 0);
            end
        end

        // R3 stuck-at-1 seen during fill
        preload(); clear_faults(); stk_addr = 3; stk_or = 8'h01;
        run(2'd2, 1'b0, ok);
        if (ok) expect_fail("R3", 2'd1, 3, 8'h00, 8'h01);

        // R4 aliased address line 2
        preload(); clear_faults(); alias_bit = 2;
        run(2'd2, 1'b0, ok);
        if (ok) expect_fail("R4", 2'd2, 4, 8'h00, 8'hFF);

        // R2 alias above the small region is invisible
        preload(); clear_faults(); alias_bit = LS;
        run(2'd0, 1'b0, ok);
        if (ok) check(pass, "R2 alias outside region", int'(pass), 1);

        // R7 stuck-at-0 on bit 7 of the last byte
        preload(); clear_faults(); stk_addr = DEPTH - 1; stk_and = 8'h7F;
        run(2'd2, 1'b0, ok);
        if (ok) expect_fail("R7", 2'd3, DEPTH - 1, 8'hAA, 8'h2A);

        // R11 start while busy
        preload(); clear_faults();
        run(2'd2, 1'b1, ok);
        if (ok) begin
            check(pass, "R11 run unaffected", int'(pass), 1);
            check(maxa == DEPTH - 1, "R11 size kept", maxa, DEPTH - 1);
        end

        // random mix
        for (int k = 0; k < 14; k++) begin
            int kind, sz, a, b, lb;
            logic [1:0] sel;
            sel  = 2'($urandom_range(0, 3));
            sz   = size_of(sel);
            kind = $urandom_range(0, 3);
            a    = $urandom_range(0, sz - 1);
            b    = $urandom_range(0, 7);
            lb   = $urandom_range(0, LL - 1);
            preload(); clear_faults();
            if (kind == 1) begin stk_addr = a; stk_or = 8'(1 << b); end
            if (kind == 2) begin stk_addr = a; stk_and = ~8'(1 << b); end
            if (kind == 3) alias_bit = lb;
            run(sel, 1'b0, ok);
            if (ok) begin
                if (kind == 0) expect_clean(sel, "rand");
                else if (kind == 1) expect_fail("R3 rand", 2'd1, a, 8'h00, 8'(1 << b));
                else if (kind == 2)
                    expect_fail("R7 rand", 2'd3, a, s0_exp(b), s0_exp(b) & ~8'(1 << b));
                else if (lb < log_of(sel))
                    expect_fail("R4 rand", 2'd2, 1 << lb, 8'h00, 8'hFF);
                else
                    check(pass, "R2 rand alias outside", int'(pass), 1);
            end
            // R8 record stays put while idle
            if (ok && fail) begin
                logic [LL-1:0] fa;
                fa = fail_addr;
                repeat (3) @(negedge clk);
                check(fail_addr == fa && done, "R8 record held", int'(fail_addr), int'(fa));
            end
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 190000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule